// File: doc/BRIEF.md
# Dual-Channel I/Q Waveform Player

This block generates periodic baseband test signals for a two-transmitter radio front end. It drives four 14-bit sample buses: an in-phase and a quadrature stream for each of two channels. Each stream comes from a sample table that is computed in logic. One shared read index addresses all four tables, so the four streams always show the same table position.

While the run input is high, the index moves forward by one entry on every rising clock edge. It wraps back to zero at a length chosen at runtime, so the length sets the period of the generated tone. The run input comes from the controller that brings up the frequency synthesizer. Until that controller raises run, every bus rests at mid-scale and the converter strobes stay quiet.

Each channel has a converter clock strobe and a converter write strobe. Both are high only during the second half of a clock period. The sample buses change on the rising edge, so the data is steady for half a period before the strobe's rising edge captures it.

Top module: `dualiq_player`

## Requirements
- R1: The reset input is synchronous and active high. After a clock edge that sees reset, all four sample buses read 14'h2000, all strobes are low and the read index is 0.
- R2: On each rising edge that sees run high, the read index advances by exactly one entry. The sample buses then show the table entries at the index held before that edge.
- R3: With an effective length L, the index steps 0, 1, ..., L-1 and then returns to 0, so each output stream repeats every L clock cycles.
- R4: The entry at index a of stream s is (s_slope*a + s_base) mod 16384. Stream 0 is channel 1 I (slope 1, base 0). Stream 1 is channel 1 Q (slope 3, base 4096). Stream 2 is channel 2 I (slope 5, base 8192). Stream 3 is channel 2 Q (slope 7, base 12288). All four buses take their entries from the same index in the same cycle.
- R5: After an edge that sees run low, all four buses read 14'h2000 and the index returns to 0. The first edge that then sees run high puts entry 0 on the buses.
- R6: In every period, each channel's clock strobe and write strobe are low during the first half. Both strobes are high during the second half only if the last rising edge saw run high and reset low. The two strobes of a channel are always equal.
- R7: A length input of 0 is treated as a length of 1, so the buses hold entry 0 on every cycle.
- R8: A length input greater than the table depth (1024) is treated as the depth.
- R9: A change of length takes effect at the next edge. If the current index is at or beyond the new length minus one, the index goes to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; one table entry per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Playback enable, raised when synthesizer bring-up is done |
| len_i | input | 11 | Requested table length (0 acts as 1, values above 1024 act as 1024) |
| ch1_i_o | output | 14 | Channel 1 in-phase samples |
| ch1_q_o | output | 14 | Channel 1 quadrature samples |
| ch2_i_o | output | 14 | Channel 2 in-phase samples |
| ch2_q_o | output | 14 | Channel 2 quadrature samples |
| ch1_dac_clk_o | output | 1 | Channel 1 converter clock strobe |
| ch1_dac_wr_o | output | 1 | Channel 1 converter write strobe |
| ch2_dac_clk_o | output | 1 | Channel 2 converter clock strobe |
| ch2_dac_wr_o | output | 1 | Channel 2 converter write strobe |

## Verification
The player is driven with a short length of 5, where several wraps show the period and the mod-16384 arithmetic of the four slopes. A length of 0 shows the index pinned at entry 0. An oversized length shows the clamp at the full 1024-entry wrap and separates it from a wrap at the raw input value. A length cut from 100 to 10 in the middle of a run separates a wrap that happens at once from one that waits for a stale limit. Dropping run, reasserting it, and a reset in the middle of a run show that playback always starts again at entry 0 from mid-scale. Every cycle also checks both halves of the period for the strobe phase.

// File: rtl/dualiq_pkg.sv
package dualiq_pkg;

    localparam int SAMP_W  = 14;
    localparam int DEPTH   = 1024;
    localparam int NSTREAM = 4;
    localparam int NCHAN   = 2;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int LEN_W   = ADDR_W + 1;

    localparam logic [SAMP_W-1:0] MID_SCALE = SAMP_W'(1) << (SAMP_W - 1);

    // Per-stream table shape: stream order is ch1 I, ch1 Q, ch2 I, ch2 Q.
    localparam int unsigned STREAM_SLOPE [NSTREAM] = '{1, 3, 5, 7};
    localparam int unsigned STREAM_BASE  [NSTREAM] = '{0, 4096, 8192, 12288};

    // One table entry, reduced modulo 2**SAMP_W.
    function automatic logic [SAMP_W-1:0] table_entry(
        input int unsigned slope,
        input int unsigned base,
        input logic [ADDR_W-1:0] idx
    );
        logic [31:0] acc;
        acc = 32'(idx) * 32'(slope) + 32'(base);
        return acc[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/dualiq_index.sv
module dualiq_index #(
    parameter int DEPTH  = dualiq_pkg::DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              active;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] last_ext;

    always_comb begin
        // Clamp the requested length into 1..DEPTH.
        if (len_i == '0) begin
            eff_len = LEN_W'(1);
        end else if (len_i > LEN_W'(DEPTH)) begin
            eff_len = LEN_W'(DEPTH);
        end else begin
            eff_len = len_i;
        end
        last_ext = eff_len - LEN_W'(1);

        st_d = st_q;
        if (rst_i || !run_i) begin
            st_d.addr   = '0;
            st_d.active = 1'b0;
        end else begin
            st_d.active = 1'b1;
            if ({1'b0, st_q.addr} >= last_ext) begin
                st_d.addr = '0;
            end else begin
                st_d.addr = st_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign active_o = st_q.active;

endmodule

// File: rtl/dualiq_table.sv
module dualiq_table #(
    parameter int          SAMP_W = dualiq_pkg::SAMP_W,
    parameter int          ADDR_W = dualiq_pkg::ADDR_W,
    parameter int unsigned SLOPE  = 1,
    parameter int unsigned BASE   = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SAMP_W-1:0] samp_o
);

    logic [SAMP_W-1:0] samp_d, samp_q;
    logic [31:0]       acc;

    always_comb begin
        acc = 32'(addr_i) * 32'(SLOPE) + 32'(BASE);
        if (rst_i || !run_i) begin
            samp_d = SAMP_W'(1) << (SAMP_W - 1);
        end else begin
            samp_d = acc[SAMP_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        samp_q <= samp_d;
    end

    assign samp_o = samp_q;

endmodule

// File: rtl/dualiq_strobe.sv
module dualiq_strobe (
    input  logic clk_i,
    input  logic rst_i,
    input  logic active_i,
    output logic dac_clk_o,
    output logic dac_wr_o
);

    // rise_q toggles on rising edges and fall_q copies it on falling edges.
    // The two differ in the first half of a period and agree in the second.
    logic rise_d, rise_q;
    logic fall_d, fall_q;
    logic second_half;

    always_comb begin
        rise_d = rst_i ? 1'b0 : ~rise_q;
        fall_d = rst_i ? 1'b0 : rise_q;
    end

    always_ff @(posedge clk_i) begin
        rise_q <= rise_d;
    end

    always_ff @(negedge clk_i) begin
        fall_q <= fall_d;
    end

    assign second_half = ~(rise_q ^ fall_q);
    assign dac_clk_o   = active_i & second_half;
    assign dac_wr_o    = active_i & second_half;

endmodule

// File: rtl/dualiq_player.sv
module dualiq_player #(
    parameter int  DEPTH  = dualiq_pkg::DEPTH,
    parameter int  SAMP_W = dualiq_pkg::SAMP_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [SAMP_W-1:0] ch1_i_o,
    output logic [SAMP_W-1:0] ch1_q_o,
    output logic [SAMP_W-1:0] ch2_i_o,
    output logic [SAMP_W-1:0] ch2_q_o,
    output logic              ch1_dac_clk_o,
    output logic              ch1_dac_wr_o,
    output logic              ch2_dac_clk_o,
    output logic              ch2_dac_wr_o
);

    import dualiq_pkg::*;

    logic [ADDR_W-1:0] addr;
    logic              active;
    logic [SAMP_W-1:0] samp  [NSTREAM];
    logic              dclk  [NCHAN];
    logic              dwr   [NCHAN];

    dualiq_index #(.DEPTH(DEPTH)) u_index (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (run_i),
        .len_i    (len_i),
        .addr_o   (addr),
        .active_o (active)
    );

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        dualiq_table #(
            .SAMP_W (SAMP_W),
            .ADDR_W (ADDR_W),
            .SLOPE  (STREAM_SLOPE[s]),
            .BASE   (STREAM_BASE[s])
        ) u_table (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .run_i  (run_i),
            .addr_i (addr),
            .samp_o (samp[s])
        );
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        dualiq_strobe u_strobe (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .active_i  (active),
            .dac_clk_o (dclk[c]),
            .dac_wr_o  (dwr[c])
        );
    end

    assign ch1_i_o       = samp[0];
    assign ch1_q_o       = samp[1];
    assign ch2_i_o       = samp[2];
    assign ch2_q_o       = samp[3];
    assign ch1_dac_clk_o = dclk[0];
    assign ch1_dac_wr_o  = dwr[0];
    assign ch2_dac_clk_o = dclk[1];
    assign ch2_dac_wr_o  = dwr[1];

endmodule

// File: rtl/dualiq_player_chk.sv
module dualiq_player_chk #(
    parameter int  DEPTH  = dualiq_pkg::DEPTH,
    parameter int  SAMP_W = dualiq_pkg::SAMP_W,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              run_i,
    input logic [LEN_W-1:0]  len_i,
    input logic [ADDR_W-1:0] addr,
    input logic [SAMP_W-1:0] ch1_i_o,
    input logic [SAMP_W-1:0] ch1_q_o,
    input logic [SAMP_W-1:0] ch2_i_o,
    input logic [SAMP_W-1:0] ch2_q_o,
    input logic              ch1_dac_clk_o,
    input logic              ch1_dac_wr_o,
    input logic              ch2_dac_clk_o,
    input logic              ch2_dac_wr_o
);

    import dualiq_pkg::*;

    localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1);

    logic [LEN_W-1:0] lim;
    logic             all_mid;
    logic             any_strobe;

    always_comb begin
        lim = (len_i == '0) ? LEN_W'(1) :
              (len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_i;
        all_mid = (ch1_i_o == MID) && (ch1_q_o == MID) &&
                  (ch2_i_o == MID) && (ch2_q_o == MID);
        any_strobe = ch1_dac_clk_o | ch1_dac_wr_o | ch2_dac_clk_o | ch2_dac_wr_o;
    end

    a_r1_reset_idle: assert property (@(posedge clk_i)
        rst_i |=> (all_mid && addr == '0 && !any_strobe));

    a_r5_halt_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (all_mid && addr == '0));

    a_r2_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && ({1'b0, addr} + LEN_W'(1) < lim)) |=> addr == $past(addr) + ADDR_W'(1));

    a_r3_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && ({1'b0, addr} + LEN_W'(1) >= lim)) |=> addr == '0);

    a_r4_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |=> (ch1_i_o == SAMP_W'(32'($past(addr)) * 1 + 0) &&
                   ch1_q_o == SAMP_W'(32'($past(addr)) * 3 + 4096) &&
                   ch2_i_o == SAMP_W'(32'($past(addr)) * 5 + 8192) &&
                   ch2_q_o == SAMP_W'(32'($past(addr)) * 7 + 12288)));

    a_r6_strobe_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !any_strobe);

endmodule

bind dualiq_player dualiq_player_chk #(.DEPTH(DEPTH), .SAMP_W(SAMP_W)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .run_i         (run_i),
    .len_i         (len_i),
    .addr          (addr),
    .ch1_i_o       (ch1_i_o),
    .ch1_q_o       (ch1_q_o),
    .ch2_i_o       (ch2_i_o),
    .ch2_q_o       (ch2_q_o),
    .ch1_dac_clk_o (ch1_dac_clk_o),
    .ch1_dac_wr_o  (ch1_dac_wr_o),
    .ch2_dac_clk_o (ch2_dac_clk_o),
    .ch2_dac_wr_o  (ch2_dac_wr_o)
);

// File: tb/tb_dualiq_player.sv
module tb_dualiq_player;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [10:0] len = '0;
    logic [13:0] c1i, c1q, c2i, c2q;
    logic        c1clk, c1wr, c2clk, c2wr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0][13:0] s;
        bit               act;
        string            tag;
    } item_t;

    item_t q[$];
    int    m_addr = 0;

    always #2 clk = ~clk;

    dualiq_player dut (
        .clk_i (clk), .rst_i (rst), .run_i (run), .len_i (len),
        .ch1_i_o (c1i), .ch1_q_o (c1q), .ch2_i_o (c2i), .ch2_q_o (c2q),
        .ch1_dac_clk_o (c1clk), .ch1_dac_wr_o (c1wr),
        .ch2_dac_clk_o (c2clk), .ch2_dac_wr_o (c2wr)
    );

    function automatic logic [13:0] ref_entry(int s, int a);
        int slope[4] = '{1, 3, 5, 7};
        int base[4]  = '{0, 4096, 8192, 12288};
        return 14'((a * slope[s] + base[s]) % 16384);
    endfunction

    task automatic check(bit ok, string tag, string what, int actual, int expect_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, actual, expect_v, $time);
        end
    endtask

    // Driver: sets inputs mid-period and queues what the next edge must produce.
    task automatic step(bit r, bit rs, int ln, string tag);
        item_t it;
        int    e;
        @(negedge clk);
        rst = rs;
        run = r;
        len = 11'(ln);
        e = (ln == 0) ? 1 : ((ln > 1024) ? 1024 : ln);
        it.tag = tag;
        if (rs || !r) begin
            for (int s = 0; s < 4; s++) it.s[s] = 14'h2000;
            it.act = 1'b0;
            m_addr = 0;
        end else begin
            for (int s = 0; s < 4; s++) it.s[s] = ref_entry(s, m_addr);
            it.act = 1'b1;
            m_addr = (m_addr >= e - 1) ? 0 : m_addr + 1;
        end
        q.push_back(it);
    endtask

    // Monitor: compares buses just after the edge, strobes in both halves.
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [3:0][13:0] got;
                it = q.pop_front();
                #1;
                got = {c2q, c2i, c1q, c1i};
                for (int s = 0; s < 4; s++)
                    check(got[s] == it.s[s], it.tag, $sformatf("stream%0d", s), got[s], it.s[s]);
                check({c1clk, c1wr, c2clk, c2wr} == 4'b0, "R6", "strobes first half",
                      {c1clk, c1wr, c2clk, c2wr}, 0);
                #2;
                check({c1clk, c1wr, c2clk, c2wr} == {4{it.act}}, "R6", "strobes second half",
                      {c1clk, c1wr, c2clk, c2wr}, {4{it.act}});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1'b0, 1'b1, 5, "R1");
        // R2 R3 R4: short list, several wraps
        repeat (2) step(1'b0, 1'b0, 5, "R5");
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0, 5, "R3");
        // R7: zero length pins the index at entry 0
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, "R7");
        // R8: oversized length wraps at the depth
        step(1'b0, 1'b0, 2000, "R5");
        for (int i = 0; i < 1030; i++) step(1'b1, 1'b0, 2000, "R8");
        // R9: length cut below the current index
        step(1'b0, 1'b0, 100, "R5");
        for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 100, "R2");
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 10, "R9");
        // R5: halt then restart from entry 0
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 10, "R5");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 10, "R5");
        // R1: reset during playback, then resume
        step(1'b1, 1'b1, 10, "R1");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 7, "R4");
        step(1'b0, 1'b0, 7, "R5");
        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule